// File: doc/BRIEF.md
# Voice Codec PCM Serial Port

This block is the serial data port of a voice codec. It runs from a master clock at 256 times the sample rate. It oversamples an incoming bit clock (16 times the sample rate) and a frame sync (at the sample rate) through synchronizers and reacts to their edges. Every frame has sixteen bit slots. During each frame the port shifts one converter sample out, MSB first, and collects one sample from the serial input.

A mode pin selects how a sample sits in the frame. In linear mode a 14-bit two's complement sample fills slots 0 to 13, and slots 14 and 15 are padding. In companded mode an 8-bit code fills slots 0 to 7, and the remaining slots hold no data. The output drives padding slots as zero, and the input discards them. The mode pin and the A-law/µ-law select are both captured when a frame starts. They are held for the whole frame on outputs that the companding logic beside this port reads. On the parallel side the port takes a transmit word with a valid strobe and returns the received word with a one-cycle valid pulse.

Top module: `pcm_serial_port`

## Requirements
- R1: A synchronous active-high reset forces `sdout_o` low, `dac_valid_o` low and `dac_word_o` to 0. After reset the port stays idle, with `sdout_o` low and no `dac_valid_o` pulse, however the bit clock toggles, until the first frame sync rising edge.
- R2: A frame starts at each rising edge of `fsync_i`, which coincides with a falling edge of `bclk_i`. Slot 0 begins at that edge, and each later falling edge of `bclk_i` moves to the next slot.
- R3: With `fmt_sel_i` = 0 (linear), the 14-bit transmit word goes out MSB first on `sdout_o` in slots 0 to 13, with bit 13 in slot 0. Slots 14 and 15 are 0.
- R4: With `fmt_sel_i` = 1 (companded), bits 7..0 of the transmit word go out MSB first in slots 0 to 7. Slots 8 to 15 are 0.
- R5: A pulse on `adc_valid_i` stores `adc_word_i`. Each frame sends the most recently stored word, so a frame with no new strobe repeats the previous word.
- R6: In linear mode, `sdin_i` is taken at the bit clock rising edge of slots 0 to 13. The slot 0 bit lands in `dac_word_o[13]`. Slots 14 and 15 have no effect on `dac_word_o`.
- R7: In companded mode, the slots 0 to 7 bits form `dac_word_o[7:0]` (slot 0 in bit 7) and `dac_word_o[13:8]` is 0. Slots 8 to 15 have no effect.
- R8: `dac_valid_o` is high for exactly one master clock cycle per frame, after the last valid slot has been taken, and `dac_word_o` is valid while it is high.
- R9: `fmt_sel_i` and `alaw_sel_i` (1 = A-law, 0 = µ-law) are sampled at frame start and appear on `frame_compand_o` and `frame_alaw_o`. A change in the middle of a frame affects neither the current frame nor these outputs until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Bit clock, 16 times the sample rate |
| fsync_i | input | 1 | Frame sync at the sample rate |
| sdin_i | input | 1 | Serial receive data |
| fmt_sel_i | input | 1 | 0 = linear 14-bit, 1 = companded 8-bit |
| alaw_sel_i | input | 1 | 1 = A-law, 0 = µ-law |
| adc_word_i | input | 14 | Parallel word to transmit |
| adc_valid_i | input | 1 | Strobe that stores `adc_word_i` |
| sdout_o | output | 1 | Serial transmit data |
| dac_word_o | output | 14 | Received word (companded code in bits 7..0) |
| dac_valid_o | output | 1 | One-cycle pulse when `dac_word_o` is new |
| frame_compand_o | output | 1 | Format latched for the current frame |
| frame_alaw_o | output | 1 | Law select latched for the current frame |

## Verification
The assertions assume the bit clock and frame sync are slow compared with the master clock: each level lasts several master cycles, so the two-flop synchronizers see every edge exactly once. They also assume that a sync rising edge lands on a bit clock falling edge and never on a rising edge. The bench produces both clocks, and the serial input, from one counter advanced on the master clock. The bit clock is low for eight master cycles and high for eight. Sync rises at the same instant as the slot 0 falling edge. Serial input bits change only at falling edges, so they are stable across every rising edge where they are taken.

// File: rtl/pcm_port_pkg.sv
`timescale 1ns/1ps
package pcm_port_pkg;

   typedef enum logic {
      FMT_LINEAR  = 1'b0,
      FMT_COMPAND = 1'b1
   } pcm_fmt_e;

   // number of data-carrying slots for a given format
   function automatic int unsigned used_slots(pcm_fmt_e f, int unsigned lin_w,
                                              int unsigned cmp_w);
      return (f == FMT_COMPAND) ? cmp_w : lin_w;
   endfunction

endpackage

// File: rtl/pcm_sync_bit.sv
`timescale 1ns/1ps
module pcm_sync_bit #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pcm_sync_bit: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[0] <= 1'b0;
            else     chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/pcm_edge_det.sv
`timescale 1ns/1ps
module pcm_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise,
   output logic fall
);
   logic lvl;
   logic lvl_q;

   pcm_sync_bit #(.STAGES(STAGES)) i_sync (
      .clk (clk),
      .rst (rst),
      .din (din),
      .dout(lvl)
   );

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= 1'b0;
      else     lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
   assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/pcm_tx_shifter.sv
`timescale 1ns/1ps
module pcm_tx_shifter
   import pcm_port_pkg::*;
#(
   parameter int SLOTS = 16,
   parameter int LIN_W = 14,
   parameter int CMP_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             shift,
   input  pcm_fmt_e         fmt,
   input  logic [LIN_W-1:0] word,
   output logic             sd
);
   localparam int LPAD = SLOTS - LIN_W;
   localparam int CPAD = SLOTS - CMP_W;

   logic [SLOTS-1:0] sr;
   logic [SLOTS-1:0] load_val;

   // left-justify the sample; trailing slots filled with zero
   assign load_val = (fmt == FMT_COMPAND) ? {word[CMP_W-1:0], {CPAD{1'b0}}}
                                          : {word, {LPAD{1'b0}}};

   always_ff @(posedge clk) begin
      if (rst)        sr <= '0;
      else if (load)  sr <= load_val;
      else if (shift) sr <= {sr[SLOTS-2:0], 1'b0};
   end

   assign sd = sr[SLOTS-1];
endmodule

// File: rtl/pcm_rx_deser.sv
`timescale 1ns/1ps
module pcm_rx_deser
   import pcm_port_pkg::*;
#(
   parameter int LIN_W = 14,
   parameter int CMP_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             capture,
   input  logic             last,
   input  pcm_fmt_e         fmt,
   input  logic             bit_in,
   output logic [LIN_W-1:0] word_o,
   output logic             valid_o
);
   logic [LIN_W-2:0] sr;

   always_ff @(posedge clk) begin
      if (rst) begin
         sr      <= '0;
         word_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (clear) begin
            sr <= '0;
         end else if (capture) begin
            sr <= {sr[LIN_W-3:0], bit_in};
            if (last) begin
               valid_o <= 1'b1;
               if (fmt == FMT_COMPAND)
                  word_o <= {{(LIN_W-CMP_W){1'b0}}, sr[CMP_W-2:0], bit_in};
               else
                  word_o <= {sr, bit_in};
            end
         end
      end
   end

   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);

   // R7
   upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_o && fmt == FMT_COMPAND) |-> (word_o[LIN_W-1:CMP_W] == '0));
endmodule

// File: rtl/pcm_serial_port.sv
`timescale 1ns/1ps
module pcm_serial_port
   import pcm_port_pkg::*;
#(
   parameter int SLOTS         = 16,
   parameter int LIN_W         = 14,
   parameter int CMP_W         = 8,
   parameter int SYNC_STAGES   = 2,
   parameter bit FRAME_ON_RISE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bclk_i,
   input  logic             fsync_i,
   input  logic             sdin_i,
   input  logic             fmt_sel_i,
   input  logic             alaw_sel_i,
   input  logic [LIN_W-1:0] adc_word_i,
   input  logic             adc_valid_i,
   output logic             sdout_o,
   output logic [LIN_W-1:0] dac_word_o,
   output logic             dac_valid_o,
   output logic             frame_compand_o,
   output logic             frame_alaw_o
);
   localparam int SW = $clog2(SLOTS);
   localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

   if (SLOTS <= LIN_W) begin : g_bad_slots
      $error("pcm_serial_port: SLOTS must exceed LIN_W");
   end
   if (LIN_W <= CMP_W || CMP_W < 2) begin : g_bad_widths
      $error("pcm_serial_port: need LIN_W > CMP_W >= 2");
   end

   logic bclk_rise, bclk_fall, fs_rise, fs_fall, sdin_s;
   logic frame_start;

   pcm_edge_det #(.STAGES(SYNC_STAGES)) i_bclk_edge (
      .clk(clk), .rst(rst), .din(bclk_i), .rise(bclk_rise), .fall(bclk_fall));

   pcm_edge_det #(.STAGES(SYNC_STAGES)) i_fsync_edge (
      .clk(clk), .rst(rst), .din(fsync_i), .rise(fs_rise), .fall(fs_fall));

   // same latency as the bit clock path keeps data aligned with its edges
   pcm_sync_bit #(.STAGES(SYNC_STAGES)) i_sdin_sync (
      .clk(clk), .rst(rst), .din(sdin_i), .dout(sdin_s));

   assign frame_start = FRAME_ON_RISE ? fs_rise : fs_fall;

   // transmit word holding register
   logic [LIN_W-1:0] adc_hold, adc_next;

   always_ff @(posedge clk) begin
      if (rst)              adc_hold <= '0;
      else if (adc_valid_i) adc_hold <= adc_word_i;
   end

   assign adc_next = adc_valid_i ? adc_word_i : adc_hold;

   // frame state
   logic          active;
   logic [SW-1:0] slot;
   pcm_fmt_e      fmt_q;
   logic          law_q;
   logic [SW:0]   valid_cnt;
   logic          in_valid, is_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         slot   <= '0;
         fmt_q  <= FMT_LINEAR;
         law_q  <= 1'b0;
      end else if (frame_start) begin
         active <= 1'b1;
         slot   <= '0;
         fmt_q  <= pcm_fmt_e'(fmt_sel_i);
         law_q  <= alaw_sel_i;
      end else if (active && bclk_fall && slot != LAST_SLOT) begin
         slot   <= slot + 1'b1;
      end
   end

   assign valid_cnt = (SW+1)'(used_slots(fmt_q, LIN_W, CMP_W));
   assign in_valid  = ({1'b0, slot} < valid_cnt);
   assign is_last   = ({1'b0, slot} == valid_cnt - 1'b1);

   pcm_tx_shifter #(.SLOTS(SLOTS), .LIN_W(LIN_W), .CMP_W(CMP_W)) i_tx (
      .clk  (clk),
      .rst  (rst),
      .load (frame_start),
      .shift(active & bclk_fall & ~frame_start),
      .fmt  (pcm_fmt_e'(fmt_sel_i)),
      .word (adc_next),
      .sd   (sdout_o)
   );

   pcm_rx_deser #(.LIN_W(LIN_W), .CMP_W(CMP_W)) i_rx (
      .clk    (clk),
      .rst    (rst),
      .clear  (frame_start),
      .capture(active & bclk_rise & in_valid & ~frame_start),
      .last   (is_last),
      .fmt    (fmt_q),
      .bit_in (sdin_s),
      .word_o (dac_word_o),
      .valid_o(dac_valid_o)
   );

   assign frame_compand_o = (fmt_q == FMT_COMPAND);
   assign frame_alaw_o    = law_q;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !active |-> (!sdout_o && !dac_valid_o));

   // R3 and R4: padding slots carry zero
   pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (active && !in_valid) |-> !sdout_o);

   // R2
   slot_adv_chk: assert property (@(posedge clk) disable iff (rst)
      (active && bclk_fall && !frame_start && slot != LAST_SLOT)
         |=> (slot == $past(slot) + 1'b1));

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !frame_start |=> ($stable(frame_alaw_o) && $stable(frame_compand_o)));
endmodule

// File: tb/test_pcm_serial_port.sv
`timescale 1ns/1ps
module test_pcm_serial_port;
   localparam int LIN_W = 14;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst = 1'b1;
   logic             bclk = 1'b1, fsync = 1'b0, sdin = 1'b0;
   logic             fmt_sel = 1'b0, alaw_sel = 1'b0;
   logic [LIN_W-1:0] adc_word = '0;
   logic             adc_valid = 1'b0;
   logic             sdout, dac_valid, frame_compand, frame_alaw;
   logic [LIN_W-1:0] dac_word;

   pcm_serial_port i_pcm_serial_port (
      .clk(clk), .rst(rst), .bclk_i(bclk), .fsync_i(fsync), .sdin_i(sdin),
      .fmt_sel_i(fmt_sel), .alaw_sel_i(alaw_sel), .adc_word_i(adc_word),
      .adc_valid_i(adc_valid), .sdout_o(sdout), .dac_word_o(dac_word),
      .dac_valid_o(dac_valid), .frame_compand_o(frame_compand),
      .frame_alaw_o(frame_alaw));

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // stimulus timing from one counter: 16 clocks per slot, 256 per frame
   logic [7:0]  cnt = 8'hFF, nx;
   bit          run = 1'b0, sync_en = 1'b0;
   logic [15:0] pat = '0;
   logic [15:0] got = '0;
   int          vcount = 0;
   logic [LIN_W-1:0] vword = '0;
   logic [LIN_W-1:0] last_adc = '0;

   always @(negedge clk) begin
      if (run) begin
         nx = cnt + 8'd1;
         cnt   <= nx;
         bclk  <= nx[3];
         fsync <= sync_en & ~nx[7];
         if (nx[3:0] == 4'd0) sdin <= pat[nx[7:4]];
      end
   end

   always @(negedge clk) begin
      if (run && cnt[3:0] == 4'd11) got[cnt[7:4]] <= sdout;
      if (dac_valid) begin
         vcount <= vcount + 1;
         vword  <= dac_word;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wait_cnt(input logic [7:0] v);
      do @(posedge clk); while (cnt != v);
   endtask

   function automatic logic [15:0] tx_exp(input bit cmp, input logic [LIN_W-1:0] w);
      logic [15:0] e = '0;
      for (int s = 0; s < 16; s++)
         if (cmp) e[s] = (s < 8)  ? w[7-s]  : 1'b0;
         else     e[s] = (s < 14) ? w[13-s] : 1'b0;
      return e;
   endfunction

   function automatic logic [LIN_W-1:0] rx_exp(input bit cmp, input logic [15:0] p);
      logic [LIN_W-1:0] r = '0;
      for (int s = 0; s < 16; s++)
         if (cmp) begin if (s < 8)  r[7-s]  = p[s]; end
         else     begin if (s < 14) r[13-s] = p[s]; end
      return r;
   endfunction

   // one full frame; checks serial out, parallel in, pulse and latched config
   task automatic do_frame(input string tag, input bit cmp, input bit law,
                           input bit give, input logic [LIN_W-1:0] w,
                           input logic [15:0] p, input bit mid);
      wait_cnt(8'd252);
      @(negedge clk);
      fmt_sel = cmp; alaw_sel = law; pat = p; got = '0; vcount = 0;
      if (give) begin
         adc_word = w; adc_valid = 1'b1; last_adc = w;
         @(negedge clk);
         adc_valid = 1'b0;
      end
      if (mid) begin
         wait_cnt(8'd100);
         @(negedge clk);
         fmt_sel = ~cmp; alaw_sel = ~law;
         repeat (8) @(negedge clk);
         chk("R9", {tag, " mid-frame law held"}, frame_alaw, law);
         chk("R9", {tag, " mid-frame format held"}, frame_compand, cmp);
      end
      wait_cnt(8'd252);
      // slot order and frame start alignment also cover R2
      chk(cmp ? "R4" : "R3", {tag, " sdout slots (R2)"}, got, tx_exp(cmp, last_adc));
      chk(cmp ? "R7" : "R6", {tag, " dac word"}, vword, rx_exp(cmp, p));
      chk("R8", {tag, " valid pulses per frame"}, vcount, 1);
      if (!mid) begin
         chk("R9", {tag, " frame law"}, frame_alaw, law);
         chk("R9", {tag, " frame format"}, frame_compand, cmp);
      end
   endtask

   task automatic t_reset;
      repeat (4) @(negedge clk);
      chk("R1", "sdout in reset", sdout, 0);
      chk("R1", "valid in reset", dac_valid, 0);
      chk("R1", "dac word in reset", dac_word, 0);
      @(negedge clk) rst = 1'b0;
   endtask

   task automatic t_idle;
      int bad = 0;
      run = 1'b1;
      adc_word = 14'h3FFF; adc_valid = 1'b1;
      @(negedge clk) adc_valid = 1'b0;
      last_adc = 14'h3FFF;
      pat = 16'hFFFF;
      repeat (400) begin
         @(negedge clk);
         if (sdout !== 1'b0 || dac_valid !== 1'b0) bad++;
      end
      chk("R1", "idle before first sync", bad, 0);
      wait_cnt(8'd200);
      @(negedge clk) sync_en = 1'b1;
   endtask

   task automatic t_linear;
      do_frame("lin-a", 1'b0, 1'b0, 1'b1, 14'h2A5C, 16'hF3A6, 1'b0);
      do_frame("lin-min", 1'b0, 1'b0, 1'b1, 14'h2000, 16'hC001, 1'b0);
   endtask

   task automatic t_repeat;
      // R5: no new strobe, previous word (14'h2000) repeats
      do_frame("R5 repeat", 1'b0, 1'b1, 1'b0, 14'h0000, 16'hFFFF, 1'b0);
   endtask

   task automatic t_compand;
      do_frame("cmp-a", 1'b1, 1'b1, 1'b1, 14'h3F5A, 16'hFF96, 1'b0);
      do_frame("cmp-mu", 1'b1, 1'b0, 1'b1, 14'h00FF, 16'hFF01, 1'b0);
   endtask

   task automatic t_midchange;
      do_frame("mid", 1'b0, 1'b1, 1'b1, 14'h1357, 16'h8ACE, 1'b1);
      do_frame("after", 1'b1, 1'b0, 1'b1, 14'h00C3, 16'h0F5A, 1'b0);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_linear();
      t_repeat();
      t_compand();
      t_midchange();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule